// File: doc/BRIEF.md
# Shared External Bus Ownership Controller

This block decides, inside one processor, when that processor may drive an external bus that it shares with a host and, optionally, with one peer processor. It samples a host bus request, a chip select, a core-priority line and the two processor request lines. All of these are active low and asynchronous, and the block synchronizes each of them before use. From these inputs it derives the bus owner. It drives the owner's output enables for the address, data, select and strobe pin groups, the host grant, its own processor request line, the core-priority pull-down and a host-access ready signal.

A host request overrides arbitration between the processors. The owner first floats its general bus pins. On the next cycle it raises the host grant, and it keeps the grant for as long as the host request stays asserted. The SDRAM control pins stay driven by the owner throughout. A slave core that needs the bus pulls the shared core-priority line. An owner that is running only background DMA then drops its request, so that the slave's core can take over.

Top module: `bus_own_ctrl`

## Requirements
- R1: The two-bit ID chooses the request line this block drives. ID 01 enables line 1 only (`req_oe_o` = 2'b01, bit 0 = line 1). ID 10 enables line 2 only (`req_oe_o` = 2'b10). ID 00 (and the reserved 11) means single-processor operation: no request line is driven, `preq_n_i` is ignored, and the local processor always owns the bus. `req_n_o` is low while the local core or DMA requests the bus on a driven line.
- R2: The ID is captured on the first clock after reset is released. Later changes on `id_i` have no effect. During reset every enable output is low and `hgnt_n_o` is high.
- R3: When `host_req_n_i` falls, the owner's `bus_oe_o` drops to all zeros 3 cycles later, and `hgnt_n_o` goes low 4 cycles later. The grant is never low while any bit of `bus_oe_o` is high.
- R4: `hgnt_n_o` stays low while the host request is held. It returns high 3 cycles after `host_req_n_i` rises, and `bus_oe_o` returns one cycle after that.
- R5: `sdram_oe_o` stays high for the owner throughout a host tenure.
- R6: Only the owner drives the grant: `hgnt_oe_o` equals ownership. A non-owner keeps `hgnt_oe_o`, `bus_oe_o` and `sdram_oe_o` low.
- R7: In a two-processor system, `preq_n_i` bit 0 is line 1 and bit 1 is line 2. The owner keeps the bus while its line stays asserted. When the owner's line is released, or when there is no owner, the asserted line with the lower ID wins. With no request at all, ownership parks on ID 01. A change on a request pin is reflected in ownership 3 cycles later.
- R8: While the host holds the bus, changes on the processor request lines do not move ownership.
- R9: Ready is driven only when both `cs_n_i` and `host_req_n_i` are asserted, 2 cycles after the pins. With `rdy_push_i` = 1 the block drives actively: `rdy_oe_o` = 1 and `rdy_o` = `mem_rdy_i`. With `rdy_push_i` = 0 it works open drain: `rdy_oe_o` = !`mem_rdy_i` and `rdy_o` = 0.
- R10: A non-owner whose core requests the bus asserts `cpa_drive_o`; an owner never does. An owner that requests only for DMA releases `req_n_o` 2 cycles after `cpa_n_i` falls. An owner whose core requests keeps its request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_i | input | 2 | Processor ID strap |
| host_req_n_i | input | 1 | Host bus request, active low, async |
| cs_n_i | input | 1 | Host chip select, active low, async |
| preq_n_i | input | 2 | Observed processor request lines, active low |
| cpa_n_i | input | 1 | Shared core-priority line, active low |
| core_req_i | input | 1 | Local core needs the external bus |
| dma_req_i | input | 1 | Local background DMA needs the external bus |
| mem_rdy_i | input | 1 | Internal access for the host is complete |
| rdy_push_i | input | 1 | 1 = ready actively driven, 0 = open drain |
| req_n_o | output | 1 | Value for the own request line, active low |
| req_oe_o | output | 2 | Drive enable per request line |
| cpa_drive_o | output | 1 | Pull the core-priority line low |
| hgnt_n_o | output | 1 | Host grant, active low |
| hgnt_oe_o | output | 1 | Drive enable of the host grant |
| bus_oe_o | output | 4 | Enables for address, data, select, strobe groups |
| sdram_oe_o | output | 1 | Enable for SDRAM control pins |
| rdy_o | output | 1 | Ready value |
| rdy_oe_o | output | 1 | Ready drive enable |

## Verification
Every asynchronous pin passes through two flops, so ready follows `cs_n_i` and `host_req_n_i` 2 cycles later, and the CPA yield follows `cpa_n_i` 2 cycles later. Registered results take one more cycle: ownership changes and the floating of `bus_oe_o` come 3 cycles after a pin change, the grant 4 cycles after. Inputs change 2 ns after a rising edge, and every check is sampled 2 ns after the edge that makes its result due. Where timing matters, the bench also samples one cycle early to show that no result arrives ahead of its cycle.

// File: rtl/bus_own_pkg.sv
package bus_own_pkg;

  typedef enum logic [1:0] {
    HS_IDLE    = 2'd0,
    HS_FLOAT   = 2'd1,
    HS_GRANT   = 2'd2,
    HS_RECLAIM = 2'd3
  } host_st_e;

  // ID 01 and 10 take part in arbitration, 00 and 11 run alone
  function automatic logic id_is_dual(input logic [1:0] id);
    return (id == 2'b01) || (id == 2'b10);
  endfunction

  // one-hot enable of the request line owned by an ID
  function automatic logic [1:0] id_line(input logic [1:0] id);
    return id_is_dual(id) ? id : 2'b00;
  endfunction

  // cur: 0 none, 1 or 2; req bit0 = line 1, bit1 = line 2, active high
  function automatic logic [1:0] next_owner(input logic [1:0] cur,
                                            input logic [1:0] req);
    logic keep;
    keep = ((cur == 2'd1) && req[0]) || ((cur == 2'd2) && req[1]);
    if (keep)        return cur;
    else if (req[0]) return 2'd1;
    else if (req[1]) return 2'd2;
    else             return 2'd0;
  endfunction

  // with no owner the bus parks on ID 01
  function automatic logic [1:0] parked(input logic [1:0] cur);
    return (cur == 2'd0) ? 2'd1 : cur;
  endfunction

endpackage

// File: rtl/bo_sync.sv
module bo_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= RST_VAL;
    else        stg[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[g] <= RST_VAL;
      else        stg[g] <= stg[g-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/bo_idcap.sv
module bo_idcap
  import bus_own_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] id_i,
  output logic [1:0] id_o,
  output logic       vld_o,
  output logic       dual_o,
  output logic [1:0] line_oe_o
);
  logic [1:0] id_q;
  logic       vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q  <= 2'b00;
      vld_q <= 1'b0;
    end else if (!vld_q) begin
      id_q  <= id_i;
      vld_q <= 1'b1;
    end
  end

  assign id_o      = id_q;
  assign vld_o     = vld_q;
  assign dual_o    = vld_q & id_is_dual(id_q);
  assign line_oe_o = vld_q ? id_line(id_q) : 2'b00;

  a_r2_id_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(vld_q) |-> $stable(id_q));
endmodule

// File: rtl/bo_arb.sv
module bo_arb
  import bus_own_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       freeze_i,
  input  logic [1:0] req_i,
  output logic [1:0] owner_o
);
  logic [1:0] cur_q;
  logic       upd_w;

  assign upd_w = en_i & ~freeze_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cur_q <= 2'd0;
    else if (upd_w) cur_q <= next_owner(cur_q, req_i);
  end

  assign owner_o = parked(cur_q);

  a_r8_hold_under_host: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_i |=> $stable(cur_q));
  a_r7_owner_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cur_q != 2'd3);
endmodule

// File: rtl/bo_host_seq.sv
module bo_host_seq
  import bus_own_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hreq_i,
  output logic grant_o,
  output logic pins_on_o,
  output logic busy_o
);
  host_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      HS_IDLE:    if (hreq_i) st_d = HS_FLOAT;
      HS_FLOAT:   st_d = hreq_i ? HS_GRANT : HS_RECLAIM;
      HS_GRANT:   if (!hreq_i) st_d = HS_RECLAIM;
      HS_RECLAIM: st_d = HS_IDLE;
      default:    st_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= HS_IDLE;
    else        st_q <= st_d;
  end

  assign grant_o   = (st_q == HS_GRANT);
  assign pins_on_o = (st_q == HS_IDLE);
  assign busy_o    = (st_q != HS_IDLE);

  a_r3_float_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_o) |-> $past(st_q == HS_FLOAT));
  a_r4_grant_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o && hreq_i) |=> grant_o);
endmodule

// File: rtl/bus_own_ctrl.sv
module bus_own_ctrl
  import bus_own_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NGRP        = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      id_i,
  input  logic            host_req_n_i,
  input  logic            cs_n_i,
  input  logic [1:0]      preq_n_i,
  input  logic            cpa_n_i,
  input  logic            core_req_i,
  input  logic            dma_req_i,
  input  logic            mem_rdy_i,
  input  logic            rdy_push_i,
  output logic            req_n_o,
  output logic [1:0]      req_oe_o,
  output logic            cpa_drive_o,
  output logic            hgnt_n_o,
  output logic            hgnt_oe_o,
  output logic [NGRP-1:0] bus_oe_o,
  output logic            sdram_oe_o,
  output logic            rdy_o,
  output logic            rdy_oe_o
);
  localparam int NSYNC = 5;

  logic [NSYNC-1:0] raw_w, syn_w;
  logic             hreq_w, cs_w, cpa_w;
  logic [1:0]       preq_w;
  logic [1:0]       id_w, line_w, owner_w;
  logic             vld_w, dual_w;
  logic             grant_w, pins_on_w, busy_w;
  logic             is_owner_w, yield_w, own_req_w, rdy_act_w;

  assign raw_w  = {cpa_n_i, cs_n_i, host_req_n_i, preq_n_i};

  bo_sync #(.W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_w), .q_o(syn_w));

  assign preq_w = ~syn_w[1:0];
  assign hreq_w = ~syn_w[2];
  assign cs_w   = ~syn_w[3];
  assign cpa_w  = ~syn_w[4];

  bo_idcap u_id (
    .clk(clk), .rst_n(rst_n), .id_i(id_i),
    .id_o(id_w), .vld_o(vld_w), .dual_o(dual_w), .line_oe_o(line_w));

  bo_host_seq u_host (
    .clk(clk), .rst_n(rst_n), .hreq_i(hreq_w),
    .grant_o(grant_w), .pins_on_o(pins_on_w), .busy_o(busy_w));

  bo_arb u_arb (
    .clk(clk), .rst_n(rst_n), .en_i(dual_w),
    .freeze_i(busy_w | hreq_w), .req_i(preq_w), .owner_o(owner_w));

  assign is_owner_w = vld_w & (dual_w ? (owner_w == id_w) : 1'b1);

  // owner running only DMA yields when another core asks for priority
  assign yield_w   = dual_w & cpa_w & is_owner_w & ~core_req_i;
  assign own_req_w = core_req_i | (dma_req_i & ~yield_w);

  assign req_oe_o    = line_w;
  assign req_n_o     = ~(own_req_w & (|line_w));
  assign cpa_drive_o = dual_w & core_req_i & ~is_owner_w;

  assign hgnt_oe_o  = is_owner_w;
  assign hgnt_n_o   = ~grant_w;
  assign bus_oe_o   = {NGRP{is_owner_w & pins_on_w}};
  assign sdram_oe_o = is_owner_w;

  assign rdy_act_w = vld_w & cs_w & hreq_w;
  assign rdy_oe_o  = rdy_act_w & (rdy_push_i | ~mem_rdy_i);
  assign rdy_o     = rdy_act_w & rdy_push_i & mem_rdy_i;

  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !hgnt_n_o |-> (bus_oe_o == '0));
  a_r5_sdram_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (hgnt_oe_o && !hgnt_n_o) |-> sdram_oe_o);
  a_r1_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_oe_o));
  a_r10_cpa_slave_only: assert property (@(posedge clk) disable iff (!rst_n)
    cpa_drive_o |-> !sdram_oe_o);
  a_r9_ready_qual: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_oe_o |-> (cs_w && hreq_w));
  a_r6_grant_src: assert property (@(posedge clk) disable iff (!rst_n)
    !hgnt_oe_o |-> (bus_oe_o == '0));
endmodule

// File: tb/bus_own_ctrl_tb.sv
module bus_own_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] id_i = 2'b01;
  logic       host_req_n_i = 1'b1, cs_n_i = 1'b1, cpa_n_i = 1'b1;
  logic [1:0] preq_n_i = 2'b11;
  logic       core_req_i = 1'b0, dma_req_i = 1'b0;
  logic       mem_rdy_i = 1'b0, rdy_push_i = 1'b0;
  logic       req_n_o, cpa_drive_o, hgnt_n_o, hgnt_oe_o, sdram_oe_o, rdy_o, rdy_oe_o;
  logic [1:0] req_oe_o;
  logic [3:0] bus_oe_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  bus_own_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .id_i(id_i), .host_req_n_i(host_req_n_i),
    .cs_n_i(cs_n_i), .preq_n_i(preq_n_i), .cpa_n_i(cpa_n_i),
    .core_req_i(core_req_i), .dma_req_i(dma_req_i), .mem_rdy_i(mem_rdy_i),
    .rdy_push_i(rdy_push_i), .req_n_o(req_n_o), .req_oe_o(req_oe_o),
    .cpa_drive_o(cpa_drive_o), .hgnt_n_o(hgnt_n_o), .hgnt_oe_o(hgnt_oe_o),
    .bus_oe_o(bus_oe_o), .sdram_oe_o(sdram_oe_o), .rdy_o(rdy_o),
    .rdy_oe_o(rdy_oe_o));

  // {cs_n, host_req_n, push, mem_rdy, exp_oe, exp_val}
  localparam logic [5:0] RDY_VEC [8] = '{
    6'b011100, 6'b101100, 6'b001111, 6'b001010,
    6'b000010, 6'b000100, 6'b111100, 6'b100000
  };

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic restart(input logic [1:0] id);
    @(posedge clk);
    #2;
    rst_n = 1'b0;
    id_i = id;
    host_req_n_i = 1'b1; cs_n_i = 1'b1; cpa_n_i = 1'b1; preq_n_i = 2'b11;
    core_req_i = 1'b0; dma_req_i = 1'b0;
    step(2);
    rst_n = 1'b1;
    step(5);
  endtask

  initial begin
    #(10 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R2 reset state
    step(2);
    chk("R2 reset enables", {bus_oe_o, sdram_oe_o, hgnt_oe_o, req_oe_o}, 8'h00);
    chk("R2 reset grant", {7'd0, hgnt_n_o}, 8'h01);
    rst_n = 1'b1;
    step(5);

    // R1 ID 01: line 1 only
    chk("R1 id01 line", {6'd0, req_oe_o}, 8'h01);
    dma_req_i = 1'b1;
    #1;
    chk("R1 req drive", {7'd0, req_n_o}, 8'h00);
    dma_req_i = 1'b0;
    // R2 later ID change ignored
    id_i = 2'b10;
    step(4);
    chk("R2 id frozen", {6'd0, req_oe_o}, 8'h01);

    // R9 ready vector table
    for (int v = 0; v < 8; v++) begin
      cs_n_i = RDY_VEC[v][5]; host_req_n_i = RDY_VEC[v][4];
      rdy_push_i = RDY_VEC[v][3]; mem_rdy_i = RDY_VEC[v][2];
      step(2);
      chk($sformatf("R9 vec%0d", v), {6'd0, rdy_oe_o, rdy_o}, {6'd0, RDY_VEC[v][1:0]});
    end
    host_req_n_i = 1'b1; cs_n_i = 1'b1;
    step(6);

    // R3/R4/R5 host tenure as parked owner ID 01
    chk("R6 parked owner", {bus_oe_o, sdram_oe_o, hgnt_oe_o, 2'b00}, 8'hFC);
    host_req_n_i = 1'b0;
    step(2);
    chk("R3 not yet floated", {4'd0, bus_oe_o}, 8'h0F);
    step(1);
    chk("R3 floated", {3'd0, bus_oe_o, hgnt_n_o}, 8'h01);
    step(1);
    chk("R3 grant", {6'd0, hgnt_n_o, sdram_oe_o}, 8'h01);
    step(5);
    chk("R4 grant held", {6'd0, hgnt_n_o, sdram_oe_o}, 8'h01);
    chk("R5 sdram kept", {7'd0, sdram_oe_o}, 8'h01);
    host_req_n_i = 1'b1;
    step(2);
    chk("R4 grant still on", {7'd0, hgnt_n_o}, 8'h00);
    step(1);
    chk("R4 grant off", {3'd0, bus_oe_o, hgnt_n_o}, 8'h01);
    step(1);
    chk("R4 pins back", {4'd0, bus_oe_o}, 8'h0F);

    // R10 CPA as owner ID 01
    preq_n_i = 2'b10;
    dma_req_i = 1'b1;
    step(4);
    chk("R10 dma request", {6'd0, req_n_o, cpa_drive_o}, 8'h00);
    cpa_n_i = 1'b0;
    step(1);
    chk("R10 not yet yield", {7'd0, req_n_o}, 8'h00);
    step(1);
    chk("R10 dma yields", {6'd0, req_n_o, cpa_drive_o}, 8'h02);
    core_req_i = 1'b1;
    #1;
    chk("R10 core keeps", {6'd0, req_n_o, cpa_drive_o}, 8'h00);

    // R1 single processor: ID 00 ignores request lines
    restart(2'b00);
    preq_n_i = 2'b00;
    step(4);
    chk("R1 id00 owner", {bus_oe_o, sdram_oe_o, hgnt_oe_o, req_oe_o}, 8'hFC);

    // R6/R7/R8 as ID 10
    restart(2'b10);
    chk("R6 non-owner", {bus_oe_o, sdram_oe_o, hgnt_oe_o, req_oe_o}, 8'h02);
    core_req_i = 1'b1;
    #1;
    chk("R10 slave pulls cpa", {7'd0, cpa_drive_o}, 8'h01);
    core_req_i = 1'b0;
    preq_n_i = 2'b00;
    step(4);
    chk("R7 lower ID wins", {7'd0, sdram_oe_o}, 8'h00);
    preq_n_i = 2'b10;
    step(4);
    chk("R7 line1 owns", {7'd0, sdram_oe_o}, 8'h00);
    preq_n_i = 2'b01;
    step(2);
    chk("R7 not yet moved", {7'd0, sdram_oe_o}, 8'h00);
    step(1);
    chk("R7 handover", {bus_oe_o, sdram_oe_o, hgnt_oe_o, 2'b00}, 8'hFC);
    preq_n_i = 2'b00;
    step(4);
    chk("R7 no preempt", {7'd0, sdram_oe_o}, 8'h01);
    host_req_n_i = 1'b0;
    step(5);
    preq_n_i = 2'b10;
    step(6);
    chk("R8 frozen owner", {6'd0, hgnt_oe_o, hgnt_n_o}, 8'h02);
    host_req_n_i = 1'b1;
    step(7);
    chk("R8 rearbitrated", {bus_oe_o, sdram_oe_o, hgnt_oe_o, 2'b00}, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule